// File: doc/BRIEF.md
# Three-Phase No-Load Detector

This block watches per-phase power samples for phases A, B and C and decides, for each phase, whether the meter is idling under a no-load condition. Two detectors run side by side. The fundamental detector looks at fundamental active and fundamental reactive power together. The apparent detector looks at apparent power alone. While a phase sits in no-load for a detector, the block drops that phase's accumulation-enable gate for the matching quantities. A downstream energy accumulator then stops integrating them, so they produce no output pulses.

Samples arrive on a valid/ready stream as packed signed 28-bit values, three phases per bus. `smp_ready` is tied high: the block takes one sample in every cycle that `smp_valid` is high, and it never applies back-pressure. Detector state changes only on an accepted sample.

A small register port holds the thresholds, a per-phase state register, sticky status bits and an interrupt mask. An active-low interrupt line goes low when an unmasked status bit is set. Software reads the status word and then the state word to find out which phase changed, and clears the status by writing 1s.

Top module: `noload_monitor`

Register addresses: 0 status (write 1 to clear), 1 mask, 2 phase state (read only), 3 active threshold, 4 reactive threshold, 5 apparent threshold. Any other address reads 0.

## Requirements
- R1: A phase is in fundamental no-load when its absolute active power is at or below the active threshold (address 3, word bits 27:0, signed) and its absolute reactive power is also at or below the reactive threshold (address 4, word bits 27:0, signed). If either magnitude is above its threshold, the phase is not in no-load.
- R2: A phase is in apparent no-load when its absolute apparent power is at or below the apparent threshold. That threshold is written as a signed 24-bit value in word bits 23:0 of address 5 and is sign-extended to 28 bits for the comparison.
- R3: A negative threshold disables the detector that uses it, and a disabled detector never reports no-load. After reset all three thresholds are negative (all ones).
- R4: `fund_acc_en[k]` is 0 exactly while phase k is in fundamental no-load. `app_acc_en[k]` is 0 exactly while phase k is in apparent no-load. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.
- R5: The phase state register (address 2) holds the fundamental no-load bits at 5:3 and the apparent no-load bits at 8:6, phase A lowest in each group. Bits 2:0 are a slot for a total-power detector that is not built here and read 0, as do all bits above 8. It updates in the same clock edge as the status bits.
- R6: Status bit 1 (fundamental) or bit 2 (apparent) is set on a sample where any phase enters or leaves no-load for that detector. A sample that changes no state sets nothing. Status bit 0 always reads 0.
- R7: Writing status with a 1 in a bit position clears that bit, and writing 0 leaves it unchanged.
- R8: `irq_n` is low while any status bit is set with its mask bit (address 1, bits 2:0) at 1, and high otherwise.
- R9: The apparent threshold reads back as four zero bits above its 28-bit sign extension. Write bits 31:24 are ignored.
- R10: The absolute value of the most negative 28-bit input (-2^27) saturates to 2^27-1.
- R11: After reset all phases are out of no-load, status and mask are 0 and `irq_n` is high. Without `smp_valid`, no detector state changes.
- R12: When a status set event and a write-1-to-clear of the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A sample set is present on the power buses |
| smp_ready | output | 1 | Always 1; no back-pressure |
| smp_act | input | 84 | Fundamental active power, phase k at bits [28k+27:28k] |
| smp_rea | input | 84 | Fundamental reactive power, same packing |
| smp_app | input | 84 | Apparent power, same packing |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| fund_acc_en | output | 3 | Per-phase enable for fundamental energy accumulation |
| app_acc_en | output | 3 | Per-phase enable for apparent energy accumulation |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a status-clear write that lands on the same edge as a sample that flips a phase's state. The bench raises `smp_valid` and a write of all ones to the status register in the same cycle, with no-load data on every phase, and then expects both status bits to be set. Saturation of the most negative input is also hard to reach, because it only shows against thresholds at the top of the range. The bench sets the active and reactive thresholds to 2^27-1, where a wrapping absolute value would give a different answer.

// File: rtl/noload_pkg.sv
package noload_pkg;
  localparam int PW  = 28;
  localparam int NPH = 3;
  localparam int DW  = 32;
  localparam int AW  = 3;
  localparam int TW  = 24;

  localparam logic [AW-1:0] ADDR_STATUS = 3'd0;
  localparam logic [AW-1:0] ADDR_MASK   = 3'd1;
  localparam logic [AW-1:0] ADDR_STATE  = 3'd2;
  localparam logic [AW-1:0] ADDR_ATHR   = 3'd3;
  localparam logic [AW-1:0] ADDR_RTHR   = 3'd4;
  localparam logic [AW-1:0] ADDR_PTHR   = 3'd5;

  // magnitude with the most negative code clamped to the largest positive one
  function automatic logic [PW-1:0] mag_sat(input logic signed [PW-1:0] v);
    if (v == {1'b1, {(PW-1){1'b0}}}) return {1'b0, {(PW-1){1'b1}}};
    else if (v[PW-1]) return -v;
    else return v;
  endfunction

  // true when magnitude is at or below a non-negative threshold
  function automatic logic under_thr(input logic [PW-1:0] m, input logic signed [PW-1:0] t);
    return !t[PW-1] && (m <= t);
  endfunction
endpackage

// File: rtl/noload_cmp.sv
module noload_cmp
  import noload_pkg::*;
(
  input  logic signed [PW-1:0] act,
  input  logic signed [PW-1:0] rea,
  input  logic signed [PW-1:0] app,
  input  logic signed [PW-1:0] act_thr,
  input  logic signed [PW-1:0] rea_thr,
  input  logic signed [PW-1:0] app_thr,
  output logic                 fund_nl,
  output logic                 app_nl
);
  logic [PW-1:0] act_m, rea_m, app_m;

  always_comb begin
    act_m   = mag_sat(act);
    rea_m   = mag_sat(rea);
    app_m   = mag_sat(app);
    fund_nl = under_thr(act_m, act_thr) && under_thr(rea_m, rea_thr);
    app_nl  = under_thr(app_m, app_thr);
  end
endmodule

// File: rtl/noload_events.sv
module noload_events
  import noload_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic [NPH-1:0] fund_nl,
  input  logic [NPH-1:0] app_nl,
  input  logic           clr_we,
  input  logic [2:0]     clr_bits,
  output logic [NPH-1:0] fund_st,
  output logic [NPH-1:0] app_st,
  output logic [2:0]     status
);
  logic [2:0] set_v, clr_v;

  always_comb begin
    set_v    = 3'b000;
    set_v[1] = fire && (fund_nl != fund_st);
    set_v[2] = fire && (app_nl != app_st);
    clr_v    = clr_we ? clr_bits : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fund_st <= '0;
      app_st  <= '0;
      status  <= 3'b000;
    end else begin
      if (fire) begin
        fund_st <= fund_nl;
        app_st  <= app_nl;
      end
      status <= ((status & ~clr_v) | set_v) & 3'b110;
    end
  end
endmodule

// File: rtl/noload_regs.sv
module noload_regs
  import noload_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [2:0]           status,
  input  logic [NPH-1:0]       fund_st,
  input  logic [NPH-1:0]       app_st,
  output logic [2:0]           mask,
  output logic signed [PW-1:0] act_thr,
  output logic signed [PW-1:0] rea_thr,
  output logic signed [PW-1:0] app_thr
);
  logic [TW-1:0] app_raw;

  assign app_thr = {{(PW-TW){app_raw[TW-1]}}, app_raw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= 3'b000;
      act_thr <= '1;
      rea_thr <= '1;
      app_raw <= '1;
    end else if (we) begin
      case (addr)
        ADDR_MASK: mask    <= wdata[2:0];
        ADDR_ATHR: act_thr <= wdata[PW-1:0];
        ADDR_RTHR: rea_thr <= wdata[PW-1:0];
        ADDR_PTHR: app_raw <= wdata[TW-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_STATUS: rdata[2:0] = status;
      ADDR_MASK:   rdata[2:0] = mask;
      ADDR_STATE:  rdata[3*NPH-1:0] = {app_st, fund_st, {NPH{1'b0}}};
      ADDR_ATHR:   rdata[PW-1:0] = act_thr;
      ADDR_RTHR:   rdata[PW-1:0] = rea_thr;
      ADDR_PTHR:   rdata[PW-1:0] = app_thr;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/noload_monitor.sv
module noload_monitor
  import noload_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [NPH*PW-1:0] smp_act,
  input  logic [NPH*PW-1:0] smp_rea,
  input  logic [NPH*PW-1:0] smp_app,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NPH-1:0]    fund_acc_en,
  output logic [NPH-1:0]    app_acc_en,
  output logic              irq_n
);
  logic signed [PW-1:0] act_thr, rea_thr, app_thr;
  logic [NPH-1:0]       fund_nl, app_nl, fund_st, app_st;
  logic [2:0]           status, mask;

  assign smp_ready = 1'b1;

  for (genvar k = 0; k < NPH; k++) begin : g_phase
    noload_cmp u_cmp (
      .act     (smp_act[k*PW +: PW]),
      .rea     (smp_rea[k*PW +: PW]),
      .app     (smp_app[k*PW +: PW]),
      .act_thr (act_thr),
      .rea_thr (rea_thr),
      .app_thr (app_thr),
      .fund_nl (fund_nl[k]),
      .app_nl  (app_nl[k])
    );
  end

  noload_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (smp_valid && smp_ready),
    .fund_nl  (fund_nl),
    .app_nl   (app_nl),
    .clr_we   (reg_we && (reg_addr == ADDR_STATUS)),
    .clr_bits (reg_wdata[2:0]),
    .fund_st  (fund_st),
    .app_st   (app_st),
    .status   (status)
  );

  noload_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .status  (status),
    .fund_st (fund_st),
    .app_st  (app_st),
    .mask    (mask),
    .act_thr (act_thr),
    .rea_thr (rea_thr),
    .app_thr (app_thr)
  );

  assign fund_acc_en = ~fund_st;
  assign app_acc_en  = ~app_st;
  assign irq_n       = ~|(status & mask);
endmodule

// File: rtl/noload_monitor_chk.sv
module noload_monitor_chk
  import noload_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic                 reg_we,
  input logic [AW-1:0]        reg_addr,
  input logic [NPH-1:0]       fund_acc_en,
  input logic [NPH-1:0]       app_acc_en,
  input logic                 irq_n,
  input logic [2:0]           status,
  input logic signed [PW-1:0] act_thr
);
  // R8: the line only releases after a status clear or a mask change
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(reg_we && (reg_addr == ADDR_STATUS || reg_addr == ADDR_MASK)));

  // R8: the line only drops after a sample or a mask change
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(smp_valid || (reg_we && reg_addr == ADDR_MASK)));

  // R11: no sample, no change of the gates
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(fund_acc_en) && $stable(app_acc_en)));

  // R3: a negative active threshold keeps the fundamental gates open
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && act_thr[PW-1] && !reg_we) |=> (&fund_acc_en));

  // R6: the fundamental status bit rises only with a gate change
  p_status_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> (fund_acc_en != $past(fund_acc_en)));

  // R12: a gate change always leaves the status bit set, whatever was written
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fund_acc_en != $past(fund_acc_en)) |-> status[1]);
endmodule

bind noload_monitor noload_monitor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .smp_valid   (smp_valid),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .fund_acc_en (fund_acc_en),
  .app_acc_en  (app_acc_en),
  .irq_n       (irq_n),
  .status      (status),
  .act_thr     (act_thr)
);

// File: tb/noload_monitor_tb.sv
`timescale 1ns/1ps
module noload_monitor_tb;
  localparam int PW = 28;
  localparam int NV = 8;
  localparam int BIG = 32'h0100000;
  localparam int MINV = -134217728;

  // table: active, reactive, apparent, expected fundamental and apparent no-load
  localparam int V_ACT [NV] = '{1000, 1001, -1000, 0, -1001, 500, 0, MINV};
  localparam int V_REA [NV] = '{2000, 0, -2000, 2001, 5, -500, 0, 0};
  localparam int V_APP [NV] = '{3000, 0, -3000, 3001, -2999, 100000, 0, MINV};
  localparam bit V_EF  [NV] = '{1, 0, 1, 0, 0, 1, 1, 0};
  localparam bit V_EA  [NV] = '{1, 1, 1, 0, 1, 0, 1, 0};

  logic clk = 0, rst_n = 0, smp_valid = 0, smp_ready, reg_we = 0, irq_n;
  logic [83:0] smp_act = '0, smp_rea = '0, smp_app = '0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [2:0] fund_acc_en, app_acc_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  noload_monitor u_dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic put(input int a0, a1, a2, r0, r1, r2, p0, p1, p2);
    smp_act = {28'(a2), 28'(a1), 28'(a0)};
    smp_rea = {28'(r2), 28'(r1), 28'(r0)};
    smp_app = {28'(p2), 28'(p1), 28'(p0)};
  endtask

  task automatic sample();
    @(negedge clk); smp_valid = 1;
    @(negedge clk); smp_valid = 0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 irq_n", 32'(irq_n), 1);
    rd(3'd2, v); check("R11 state", v, 0);
    rd(3'd0, v); check("R11 status", v, 0);
    rd(3'd1, v); check("R11 mask", v, 0);
    check("R4 reset gates", {26'd0, fund_acc_en, app_acc_en}, 32'h3F);
    rd(3'd5, v); check("R3 reset apparent thr", v, 32'h0FFFFFFF);
    // R3 disabled detectors with zero power
    put(0,0,0,0,0,0,0,0,0); sample();
    rd(3'd2, v); check("R3 disabled state", v, 0);
    rd(3'd0, v); check("R3 disabled status", v, 0);
    // R9 readback
    wr(3'd5, 32'hFF80_0123);
    rd(3'd5, v); check("R9 sext readback", v, 32'h0F80_0123);
    wr(3'd5, 32'hAB00_0BB8);
    rd(3'd5, v); check("R9 upper ignored", v, 32'h0000_0BB8);
    wr(3'd3, 1000); wr(3'd4, 2000);
    // R1 R2 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      int k = i % 3;
      int a[3], r[3], p[3];
      logic [31:0] e;
      for (int j = 0; j < 3; j++) begin
        a[j] = (j == k) ? V_ACT[i] : BIG;
        r[j] = (j == k) ? V_REA[i] : BIG;
        p[j] = (j == k) ? V_APP[i] : BIG;
      end
      put(a[0], a[1], a[2], r[0], r[1], r[2], p[0], p[1], p[2]);
      sample();
      e = (32'(V_EF[i]) << (3 + k)) | (32'(V_EA[i]) << (6 + k));
      rd(3'd2, v); check("R1 R2 R5 state", v, e);
      check("R4 gates", {26'd0, fund_acc_en, app_acc_en},
            {26'd0, ~e[5:3], ~e[8:6]});
    end
    // R6 R7 R8 entry, clear, mask and exit
    wr(3'd0, 7); wr(3'd1, 2);
    put(BIG,0,BIG, BIG,0,BIG, BIG,0,BIG); sample();
    rd(3'd2, v); check("R5 phase B", v, 32'h90);
    rd(3'd0, v); check("R6 entry status", v, 6);
    check("R8 irq low", 32'(irq_n), 0);
    wr(3'd0, 2);
    rd(3'd0, v); check("R7 clear one", v, 4);
    check("R8 irq masked", 32'(irq_n), 1);
    wr(3'd0, 0);
    rd(3'd0, v); check("R7 write zero", v, 4);
    wr(3'd1, 4);
    check("R8 irq mask on", 32'(irq_n), 0);
    wr(3'd0, 7);
    check("R8 irq cleared", 32'(irq_n), 1);
    sample();
    rd(3'd0, v); check("R6 no change", v, 0);
    put(BIG,BIG,BIG, BIG,BIG,BIG, BIG,BIG,BIG); sample();
    rd(3'd0, v); check("R6 exit status", v, 6);
    rd(3'd2, v); check("R6 exit state", v, 0);
    // R11 no valid means no change
    wr(3'd0, 7);
    put(0,0,0,0,0,0,0,0,0);
    repeat (3) @(negedge clk);
    rd(3'd2, v); check("R11 hold state", v, 0);
    rd(3'd0, v); check("R11 hold status", v, 0);
    // R12 set beats clear
    @(negedge clk); smp_valid = 1; reg_we = 1; reg_addr = 3'd0; reg_wdata = 7;
    @(negedge clk); smp_valid = 0; reg_we = 0;
    rd(3'd0, v); check("R12 set wins", v, 6);
    rd(3'd2, v); check("R12 state", v, 32'h1F8);
    // R10 saturation
    wr(3'd3, 32'h07FF_FFFF); wr(3'd4, 32'h07FF_FFFF); wr(3'd5, 32'h007F_FFFF);
    put(MINV,MINV,MINV, 0,0,0, MINV,MINV,MINV); sample();
    rd(3'd2, v); check("R10 saturated", v, 32'h038);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule